// File: doc/BRIEF.md
# Quad-SPI Profile Streamer with Delayed Update Strobe

This block delivers a serialized register-update profile to a four-channel frequency synthesizer. Software-side logic writes the profile as 32-bit words on a simple write port. The block holds them in a small transmit buffer and shifts them out on a quad-SPI link, which has four data lines, a serial clock and an active-low chip select. The word that carries the end-of-profile mark is the commit.

A commit starts a one-shot timer. After a programmed delay, the timer raises an update strobe for a programmed number of cycles. The synthesizer applies every staged change on that strobe, so all channels and parameters change at the same moment. The timer does not track the serial transfer. The delay must therefore cover the time needed to shift the whole profile out.

Two status flags are provided. A stall flag shows that a profile began while earlier words were still waiting in the buffer. A sticky overflow flag shows that a word was dropped because the buffer was full.

Top module: `qspi_profile_streamer`

## Requirements
- R1: After a synchronous reset, `qspi_cs_n` is 1, `qspi_sclk` is 0, `update_strobe` is 0, and `stall_flag` and `ovf_flag` are 0.
- R2: The transmit buffer holds `DEPTH` (default 4) whole 32-bit words. Accepted words are sent in the order they were written. The largest profile is therefore 16 bytes; shorter byte counts must be padded to whole words before they are written.
- R3: Each word goes out as 8 nibbles on `qspi_io`, bits 31..28 first. `qspi_sclk` idles low and has a period of `CLK_DIV` system cycles. `qspi_io` changes only while `qspi_sclk` is low, so it is stable at every rising edge of `qspi_sclk`.
- R4: `qspi_cs_n` goes low when the first word of a profile is loaded. It stays low, with no gap between buffered words, until the nibbles of the word written with `wr_last`=1 have all been shifted out. It then returns high for at least one cycle before the next profile.
- R5: A commit is an accepted write with `wr_last`=1. It captures `cfg_delay` (D) and `cfg_width` (W); a value of 0 counts as 1. Take the commit clock edge as edge 0. `update_strobe` is high after edges D through D+W-1 and low otherwise.
- R6: A commit that arrives while the timer is counting or the strobe is high drops the strobe and restarts the timing from the new commit.
- R7: The strobe timing is independent of the serial transfer. The strobe can rise while `qspi_cs_n` is still low.
- R8: On the first write of each profile, `stall_flag` is set to 1 if the buffer holds any word at that moment, and to 0 otherwise.
- R9: A write while the buffer is full is dropped and never appears on the link. It sets `ovf_flag`, which stays set until `ovf_clr` is pulsed. A new overflow in the same cycle as `ovf_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one profile word |
| wr_data | input | 32 | Profile word |
| wr_last | input | 1 | Marks the word that ends and commits the profile |
| cfg_delay | input | TMR_W | Cycles from commit to the strobe rising |
| cfg_width | input | TMR_W | Strobe high time in cycles |
| ovf_clr | input | 1 | Write-one pulse that clears the overflow flag |
| qspi_sclk | output | 1 | Serial clock |
| qspi_cs_n | output | 1 | Active-low chip select |
| qspi_io | output | 4 | Quad data lines |
| update_strobe | output | 1 | Apply-settings strobe for the synthesizer |
| stall_flag | output | 1 | Profile started while the buffer was not empty |
| ovf_flag | output | 1 | Sticky overflow flag (word dropped) |

## Verification
The hardest state to reach is a full buffer, because the transmitter removes the first word one cycle after it lands. The bench therefore writes six words on consecutive cycles. Four are held, one is already in the shifter, and the sixth is dropped while `ovf_clr` is asserted, which exercises the rule that a new overflow wins over a clear. A stalled profile start is produced by writing a new first word in the cycle right after a four-word commit. Strobe timing is swept over every delay and width from 1 to 4, plus the zero case, and a restart is forced by a second commit inside the delay window.

// File: rtl/qps_pkg.sv
package qps_pkg;

    localparam int QPS_WORD_W = 32;
    localparam int QPS_NIB_W  = 4;
    localparam int QPS_NIBS   = QPS_WORD_W / QPS_NIB_W;

    typedef struct packed {
        logic                  last;
        logic [QPS_WORD_W-1:0] data;
    } qps_word_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_LOW,
        TX_HIGH,
        TX_WAIT
    } tx_state_e;

    typedef enum logic [1:0] {
        TM_IDLE,
        TM_DELAY,
        TM_PULSE
    } tm_state_e;

    // Counts of zero behave as one; returns the reload value for a down-counter.
    function automatic int unsigned minus_one_sat(input int unsigned v);
        return (v == 0) ? 0 : v - 1;
    endfunction

endpackage

// File: rtl/qps_fifo.sv
module qps_fifo
    import qps_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  qps_word_t push_word,
    input  logic      pop,
    output qps_word_t pop_word,
    output logic      empty,
    output logic      full
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    qps_word_t       mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic [CNTW-1:0] count;
    logic            do_push, do_pop;

    assign full     = (count == CNTW'(DEPTH));
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_word = mem[rptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= push_word;
                wptr      <= next_ptr(wptr);
            end
            if (do_pop) rptr <= next_ptr(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNTW'(DEPTH));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> full);

endmodule

// File: rtl/qps_qspi_tx.sv
module qps_qspi_tx
    import qps_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fifo_empty,
    input  qps_word_t            fifo_word,
    output logic                 fifo_pop,
    output logic                 qspi_sclk,
    output logic                 qspi_cs_n,
    output logic [QPS_NIB_W-1:0] qspi_io
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int NW   = $clog2(QPS_NIBS);

    tx_state_e             state;
    logic [CW-1:0]         cnt;
    logic [NW-1:0]         nib;
    logic [QPS_WORD_W-1:0] shreg;
    logic                  is_last;
    logic                  half_done, nib_last, load;

    assign half_done = (cnt == CW'(HALF - 1));
    assign nib_last  = (nib == NW'(QPS_NIBS - 1));
    assign load      = !fifo_empty &&
                       ((state == TX_IDLE) || (state == TX_WAIT) ||
                        (state == TX_HIGH && half_done && nib_last && !is_last));
    assign fifo_pop  = load;
    assign qspi_io   = shreg[QPS_WORD_W-1 -: QPS_NIB_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            cnt       <= '0;
            nib       <= '0;
            shreg     <= '0;
            is_last   <= 1'b0;
            qspi_sclk <= 1'b0;
            qspi_cs_n <= 1'b1;
        end else begin
            if (load) begin
                shreg   <= fifo_word.data;
                is_last <= fifo_word.last;
                nib     <= '0;
                cnt     <= '0;
            end
            case (state)
                TX_IDLE: begin
                    if (load) begin
                        qspi_cs_n <= 1'b0;
                        state     <= TX_LOW;
                    end
                end
                TX_LOW: begin
                    if (half_done) begin
                        cnt       <= '0;
                        qspi_sclk <= 1'b1;
                        state     <= TX_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TX_HIGH: begin
                    if (half_done) begin
                        qspi_sclk <= 1'b0;
                        if (nib_last) begin
                            if (is_last) begin
                                cnt       <= '0;
                                qspi_cs_n <= 1'b1;
                                state     <= TX_IDLE;
                            end else if (load) begin
                                state <= TX_LOW;
                            end else begin
                                cnt   <= '0;
                                state <= TX_WAIT;
                            end
                        end else begin
                            cnt   <= '0;
                            shreg <= shreg << QPS_NIB_W;
                            nib   <= nib + 1'b1;
                            state <= TX_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TX_WAIT: begin
                    if (load) state <= TX_LOW;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assert_clock_idle_R3: assert property (@(posedge clk) disable iff (rst)
        qspi_cs_n |-> !qspi_sclk);

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
        qspi_sclk |-> $stable(qspi_io));

    assert_frame_close_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(qspi_cs_n) |-> $fell(qspi_sclk));

endmodule

// File: rtl/qps_update_timer.sv
module qps_update_timer
    import qps_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [TMR_W-1:0] delay,
    input  logic [TMR_W-1:0] width,
    output logic             strobe
);
    tm_state_e        state;
    logic [TMR_W-1:0] cnt;
    logic [TMR_W-1:0] width_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TM_IDLE;
            cnt     <= '0;
            width_q <= '0;
            strobe  <= 1'b0;
        end else if (start) begin
            state   <= TM_DELAY;
            cnt     <= TMR_W'(minus_one_sat(32'(delay)));
            width_q <= width;
            strobe  <= 1'b0;
        end else begin
            case (state)
                TM_DELAY: begin
                    if (cnt == '0) begin
                        strobe <= 1'b1;
                        cnt    <= TMR_W'(minus_one_sat(32'(width_q)));
                        state  <= TM_PULSE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                TM_PULSE: begin
                    if (cnt == '0) begin
                        strobe <= 1'b0;
                        state  <= TM_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= TM_IDLE;
            endcase
        end
    end

    assert_restart_drops_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> !strobe);

    assert_rise_after_delay_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe) |-> $past(state == TM_DELAY));

endmodule

// File: rtl/qspi_profile_streamer.sv
module qspi_profile_streamer
    import qps_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int CLK_DIV = 4,
    parameter int TMR_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [QPS_WORD_W-1:0] wr_data,
    input  logic                  wr_last,
    input  logic [TMR_W-1:0]      cfg_delay,
    input  logic [TMR_W-1:0]      cfg_width,
    input  logic                  ovf_clr,
    output logic                  qspi_sclk,
    output logic                  qspi_cs_n,
    output logic [QPS_NIB_W-1:0]  qspi_io,
    output logic                  update_strobe,
    output logic                  stall_flag,
    output logic                  ovf_flag
);
    qps_word_t in_word, out_word;
    logic      fifo_empty, fifo_full, fifo_pop;
    logic      accept, commit, prof_open, prof_start;

    assign in_word    = '{last: wr_last, data: wr_data};
    assign accept     = wr_en && !fifo_full;
    assign commit     = accept && wr_last;
    assign prof_start = wr_en && !prof_open;

    qps_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_en),
        .push_word (in_word),
        .pop       (fifo_pop),
        .pop_word  (out_word),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    qps_qspi_tx #(.CLK_DIV(CLK_DIV)) tx_i (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .fifo_word  (out_word),
        .fifo_pop   (fifo_pop),
        .qspi_sclk  (qspi_sclk),
        .qspi_cs_n  (qspi_cs_n),
        .qspi_io    (qspi_io)
    );

    qps_update_timer #(.TMR_W(TMR_W)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .start  (commit),
        .delay  (cfg_delay),
        .width  (cfg_width),
        .strobe (update_strobe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prof_open  <= 1'b0;
            stall_flag <= 1'b0;
            ovf_flag   <= 1'b0;
        end else begin
            if (accept) prof_open <= !wr_last;
            if (prof_start) stall_flag <= !fifo_empty;
            if (wr_en && fifo_full) ovf_flag <= 1'b1;
            else if (ovf_clr)       ovf_flag <= 1'b0;
        end
    end

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(wr_en));

endmodule

// File: tb/qspi_profile_streamer_tb_top.sv
`timescale 1ns/1ps
module qspi_profile_streamer_tb_top;
    localparam int DEPTH = 4;
    localparam int DIV   = 4;
    localparam int TW    = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, wr_last = 1'b0, ovf_clr = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [TW-1:0] cfg_delay = '0, cfg_width = '0;
    logic          sclk, cs_n, strobe, stall, ovf;
    logic [3:0]    io;

    always #10 clk = ~clk;

    qspi_profile_streamer #(.DEPTH(DEPTH), .CLK_DIV(DIV), .TMR_W(TW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
        .cfg_delay(cfg_delay), .cfg_width(cfg_width), .ovf_clr(ovf_clr),
        .qspi_sclk(sclk), .qspi_cs_n(cs_n), .qspi_io(io),
        .update_strobe(strobe), .stall_flag(stall), .ovf_flag(ovf)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Wire monitor: captures nibbles at rising sclk edges.
    logic [3:0]  nibs [0:255];
    int          nib_n = 0, cs_rises = 0, sp_err = 0, cyc = 0, prev_rise = 0;
    bit          have_prev = 0, chk_sp = 1;
    logic        sclk_q = 1'b0, cs_q = 1'b1;
    logic [31:0] exp_w [0:15];
    int          exp_n = 0;

    always @(negedge clk) begin
        cyc++;
        if (!cs_n && sclk && !sclk_q) begin
            if (nib_n < 256) nibs[nib_n] = io;
            nib_n++;
            if (chk_sp && have_prev && (cyc - prev_rise) != DIV) sp_err++;
            prev_rise = cyc;
            have_prev = 1;
        end
        if (cs_n) have_prev = 0;
        if (cs_n && !cs_q) cs_rises++;
        sclk_q = sclk;
        cs_q   = cs_n;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] gen_word(input int s);
        return (32'h9E37_79B9 * (s + 1)) ^ (32'(s) << 7);
    endfunction

    task automatic clear_mon();
        @(posedge clk);
        nib_n = 0; cs_rises = 0; sp_err = 0; have_prev = 0; exp_n = 0;
        @(negedge clk);
    endtask

    // Called at a negedge; the write is taken at the following posedge.
    task automatic push(input logic [31:0] d, input logic l);
        wr_en = 1'b1; wr_data = d; wr_last = l;
        exp_w[exp_n] = d;
        exp_n++;
        @(negedge clk);
        wr_en = 1'b0; wr_last = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_wire(input string req, input int rises);
        logic [31:0] w;
        check(nib_n == exp_n * 8, {req, " nibble count"}, 32'(nib_n), 32'(exp_n * 8));
        for (int i = 0; i < exp_n; i++) begin
            w = '0;
            for (int k = 0; k < 8; k++) w = {w[27:0], nibs[i*8+k]};
            check(w == exp_w[i], {req, " word on wire"}, w, exp_w[i]);
        end
        check(cs_rises == rises, "R4 chip-select frame count", 32'(cs_rises), 32'(rises));
        check(sp_err == 0, "R3 sclk period", 32'(sp_err), 0);
    endtask

    initial begin
        bit          tm_ok;
        bit          r7_done;
        logic [31:0] bad;
        rst = 1'b1;
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1 cs_n", 32'(cs_n), 1);
        check(sclk == 1'b0, "R1 sclk", 32'(sclk), 0);
        check(strobe == 1'b0 && stall == 1'b0 && ovf == 1'b0, "R1 flags",
              {29'd0, strobe, stall, ovf}, 0);

        // R3: single word, nibble order and clock rate; R8 clean start
        cfg_delay = 16'd60; cfg_width = 16'd2;
        clear_mon();
        push(32'h1234_5678, 1'b1);
        check(stall == 1'b0, "R8 stall on empty buffer", 32'(stall), 0);
        idle(80);
        chk_wire("R3", 1);

        // R2/R4: four-word profile in one continuous frame
        clear_mon();
        for (int i = 0; i < 4; i++) push(gen_word(i), i == 3);
        idle(160);
        chk_wire("R2", 1);

        // R5 sweep of delay and width; R7 strobe during transfer
        r7_done = 0;
        for (int d = 0; d <= 4; d++) begin
            for (int wd = 0; wd <= 4; wd++) begin
                int de, we;
                de = (d == 0) ? 1 : d;
                we = (wd == 0) ? 1 : wd;
                cfg_delay = TW'(d); cfg_width = TW'(wd);
                clear_mon();
                push(gen_word(10 + d * 5 + wd), 1'b1);
                tm_ok = (strobe == 1'b0);
                bad = 0;
                for (int j = 1; j <= de + we + 2; j++) begin
                    @(negedge clk);
                    if (strobe != ((j >= de) && (j < de + we))) begin
                        tm_ok = 0;
                        bad = 32'(j);
                    end
                    if (!r7_done && strobe) begin
                        check(cs_n == 1'b0, "R7 strobe while frame active", 32'(cs_n), 0);
                        r7_done = 1;
                    end
                end
                check(tm_ok, $sformatf("R5 strobe window d=%0d w=%0d (bad cycle)", d, wd), bad, 0);
                idle(40);
                chk_wire("R5", 1);
            end
        end

        // R6: second commit inside delay restarts the timer
        cfg_delay = 16'd10; cfg_width = 16'd3;
        clear_mon();
        push(gen_word(40), 1'b1);
        tm_ok = 1;
        for (int j = 1; j <= 3; j++) begin
            @(negedge clk);
            if (strobe) tm_ok = 0;
        end
        push(gen_word(41), 1'b1);
        if (strobe) tm_ok = 0;
        for (int j = 1; j <= 14; j++) begin
            @(negedge clk);
            if (strobe != (j >= 10 && j <= 12)) tm_ok = 0;
        end
        check(tm_ok, "R6 restart timing", 32'(tm_ok), 1);
        idle(80);
        chk_wire("R6", 2);

        // R8: profile started while previous words are still buffered
        cfg_delay = 16'd200; cfg_width = 16'd1;
        clear_mon();
        for (int i = 0; i < 4; i++) push(gen_word(50 + i), i == 3);
        push(gen_word(60), 1'b1);
        check(stall == 1'b1, "R8 stall raised", 32'(stall), 1);
        idle(200);
        chk_wire("R8", 2);
        clear_mon();
        push(gen_word(61), 1'b1);
        check(stall == 1'b0, "R8 stall cleared on empty start", 32'(stall), 0);
        idle(50);
        chk_wire("R8", 1);

        // R9: overflow, dropped word, set wins over clear, then clear
        clear_mon();
        check(ovf == 1'b0, "R9 no overflow yet", 32'(ovf), 0);
        for (int i = 0; i < 5; i++) push(gen_word(70 + i), 1'b0);
        ovf_clr = 1'b1;
        push(gen_word(99), 1'b0);
        exp_n--;
        ovf_clr = 1'b0;
        check(ovf == 1'b1, "R9 overflow set wins over clear", 32'(ovf), 1);
        idle(40);
        check(ovf == 1'b1, "R9 overflow sticky", 32'(ovf), 1);
        push(gen_word(80), 1'b1);
        idle(220);
        chk_wire("R9", 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check(ovf == 1'b0, "R9 overflow cleared", 32'(ovf), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete (R1..)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule